// File: doc/BRIEF.md
# Select-Gated Byte Serial Slave Port

This block is the slave end of a clock-synchronous serial link that carries command traffic between a host processor and a speech-playback core. The host owns the serial clock, the data line into the block and an active-low select. Received bytes come out on a parallel bus with a one-cycle valid strobe. Outgoing bytes are taken from a parallel source through a ready/valid handshake, and a message-ready flag tells the host that there is something to read.

All three host pins are brought into the system clock domain through a two-flop synchronizer, and serial clock edges are detected there. The system clock must therefore run at least eight times faster than the serial clock. The data-output pin is modelled as a value plus an output enable. The enable follows the raw select pin, so the pad floats whenever the host deselects the block, and this holds even while the block is in reset.

Top module: `sync_serial_slave`

## Requirements
- R1: A received unit is 8 bits, sampled on rising serial clock edges, most significant bit first. After the eighth rising edge of a frame, `rx_data_o` holds the byte and `rx_valid_o` is high for exactly one system cycle.
- R2: Transmitted bits change only on falling serial clock edges. Each byte goes out most significant bit first, so the host sees bit 7 before its first rising edge.
- R3: Outside reset, `sdo_oe_o` is low whenever `sel_n_i` is high, and it drops in the same cycle that `sel_n_i` rises.
- R4: While `rst` is high, `sdo_oe_o` equals the inverse of `sel_n_i` and `sdo_o` is 0.
- R5: Outside reset, after `sel_n_i` goes low, `sdo_oe_o` stays low until the first falling serial clock edge has been detected. From then on it is high until select is released.
- R6: Raising `sel_n_i` part way through a byte discards the partial byte, with no `rx_valid_o` pulse. It also clears both bit counters, so the next selected frame receives and transmits a whole byte from bit 7.
- R7: If `tx_valid_i` is low at the start of a byte frame, the block shifts out 0x00 for that byte.
- R8: `msg_ready_o` is low during reset and goes high one cycle after `tx_valid_i` is seen high. It goes low once the byte taken with `tx_last_i` high has had its final bit sampled by the host.
- R9: `tx_ready_o` pulses for one system cycle at the first falling edge of every byte frame, whether or not a byte is offered. A byte is taken when `tx_ready_o` and `tx_valid_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| sdi_i | input | 1 | Serial data from the host |
| sel_n_i | input | 1 | Active-low select from the host |
| rx_data_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| tx_data_i | input | 8 | Byte offered for transmission |
| tx_last_i | input | 1 | Offered byte ends the outgoing message |
| tx_valid_i | input | 1 | A byte is offered |
| tx_ready_o | output | 1 | Byte is taken in this cycle if valid |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| msg_ready_o | output | 1 | An outgoing message is pending for the host |

## Verification
The hardest situation to reach from the ports is a select release in the middle of a byte while a transmit byte has already been loaded. It must leave no receive strobe behind, and the receive and transmit counters must both restart at bit 7. The bench reaches it with a partial-frame host task that clocks four bits and then deselects. It follows this with a whole frame and checks that the scoreboard sees exactly one received byte and that a freshly queued transmit byte comes out intact. The clearing of message-ready on the last sampled bit is reached by queueing a two-byte message and checking the flag between its bytes and after the final one.

// File: rtl/sss_pkg.sv
package sss_pkg;

    localparam int unsigned UNIT_W = 8;

    // raw host pins as seen through one synchronizer stage
    typedef struct packed {
        logic sclk;
        logic sdi;
        logic sel_n;
    } pins_t;

    // events derived in the system clock domain
    typedef struct packed {
        logic rise;   // serial clock rising edge detected
        logic fall;   // serial clock falling edge detected
        logic sel;    // synchronized select, active high
    } evt_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b1, sdi: 1'b0, sel_n: 1'b1};

    function automatic logic at_last(input int unsigned cnt, input int unsigned width);
        return cnt == width - 1;
    endfunction

endpackage

// File: rtl/sss_sync.sv
module sss_sync
    import sss_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_i,
    output evt_t  evt_o,
    output logic  sdi_o
);

    localparam int unsigned DEPTH = STAGES + 1;   // one extra stage holds edge history

    pins_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= PINS_IDLE;
        end else begin
            stage_q[0] <= pins_i;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    always_comb begin
        evt_o.rise = stage_q[STAGES-1].sclk & ~stage_q[STAGES].sclk;
        evt_o.fall = ~stage_q[STAGES-1].sclk & stage_q[STAGES].sclk;
        evt_o.sel  = ~stage_q[STAGES-1].sel_n;
        sdi_o      = stage_q[STAGES-1].sdi;
    end

endmodule

// File: rtl/sss_rx.sv
module sss_rx
    import sss_pkg::*;
#(
    parameter int unsigned W = UNIT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         evt_i,
    input  logic         sdi_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         done_o      // last bit of a unit sampled in this cycle
);

    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sh_q;
    logic [W-1:0]  next_sh;
    logic          last_bit;

    assign next_sh  = {sh_q[W-2:0], sdi_i};
    assign last_bit = at_last(int'(cnt_q), W);
    assign done_o   = evt_i.rise & evt_i.sel & last_bit;

    always_ff @(posedge clk) begin
        if (rst || !evt_i.sel) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (evt_i.rise) begin
                sh_q  <= next_sh;
                cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
                if (last_bit) valid_o <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
        end else if (done_o) begin
            data_o <= next_sh;
        end
    end

endmodule

// File: rtl/sss_tx.sv
module sss_tx
    import sss_pkg::*;
#(
    parameter int unsigned W = UNIT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         evt_i,
    input  logic [W-1:0] data_i,
    input  logic         last_i,
    input  logic         valid_i,
    output logic         ready_o,
    output logic         bit_o,
    output logic         active_o,    // first falling edge of the selection seen
    output logic         load_last_o  // the byte ending a message is taken now
);

    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sh_q;
    logic          frame_start;

    assign frame_start = evt_i.fall & evt_i.sel & (cnt_q == '0);
    assign ready_o     = frame_start;
    assign load_last_o = frame_start & valid_i & last_i;
    assign bit_o       = sh_q[W-1];

    always_ff @(posedge clk) begin
        if (rst || !evt_i.sel) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            active_o <= 1'b0;
        end else if (evt_i.fall) begin
            active_o <= 1'b1;
            cnt_q    <= at_last(int'(cnt_q), W) ? '0 : cnt_q + 1'b1;
            if (frame_start) begin
                sh_q <= valid_i ? data_i : '0;   // pad with zero when nothing is offered
            end else begin
                sh_q <= {sh_q[W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/sync_serial_slave.sv
module sync_serial_slave
    import sss_pkg::*;
#(
    parameter int unsigned W           = UNIT_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_i,
    input  logic         sdi_i,
    input  logic         sel_n_i,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o,
    input  logic [W-1:0] tx_data_i,
    input  logic         tx_last_i,
    input  logic         tx_valid_i,
    output logic         tx_ready_o,
    output logic         sdo_o,
    output logic         sdo_oe_o,
    output logic         msg_ready_o
);

    pins_t pins;
    evt_t  evt;
    logic  sdi_s;
    logic  rx_done;
    logic  tx_bit;
    logic  tx_active;
    logic  load_last;
    logic  last_in_flight_q;
    logic  handshake;
    logic  fall_evt;

    assign pins      = '{sclk: sclk_i, sdi: sdi_i, sel_n: sel_n_i};
    assign fall_evt  = evt.fall;
    assign handshake = tx_ready_o & tx_valid_i;

    sss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins),
        .evt_o  (evt),
        .sdi_o  (sdi_s)
    );

    sss_rx #(.W(W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .sdi_i   (sdi_s),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o),
        .done_o  (rx_done)
    );

    sss_tx #(.W(W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .data_i      (tx_data_i),
        .last_i      (tx_last_i),
        .valid_i     (tx_valid_i),
        .ready_o     (tx_ready_o),
        .bit_o       (tx_bit),
        .active_o    (tx_active),
        .load_last_o (load_last)
    );

    // pad model: enable follows the raw select, data forced low in reset
    assign sdo_oe_o = ~sel_n_i & (rst | tx_active);
    assign sdo_o    = rst ? 1'b0 : tx_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_in_flight_q <= 1'b0;
            msg_ready_o      <= 1'b0;
        end else begin
            if (!evt.sel) begin
                last_in_flight_q <= 1'b0;
            end else if (load_last) begin
                last_in_flight_q <= 1'b1;
            end else if (rx_done) begin
                last_in_flight_q <= 1'b0;
            end

            if (rx_done && last_in_flight_q) begin
                msg_ready_o <= 1'b0;
            end else if (tx_valid_i && !handshake) begin
                msg_ready_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sync_serial_slave_chk.sv
module sync_serial_slave_chk (
    input logic clk,
    input logic rst,
    input logic sel_n_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic rx_valid_o,
    input logic tx_ready_o,
    input logic msg_ready_o,
    input logic fall_evt
);

    p_rx_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    p_oe_sel_r3: assert property (@(posedge clk) disable iff (rst)
        sel_n_i |-> !sdo_oe_o);

    p_rst_pin_r4: assert property (@(posedge clk)
        rst |-> ((sdo_oe_o == !sel_n_i) && !sdo_o));

    p_oe_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdo_oe_o) && $past(!sel_n_i)) |-> $past(fall_evt));

    p_msg_rst_r8: assert property (@(posedge clk)
        rst |=> !msg_ready_o);

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |=> !tx_ready_o);

endmodule

bind sync_serial_slave sync_serial_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_n_i     (sel_n_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .rx_valid_o  (rx_valid_o),
    .tx_ready_o  (tx_ready_o),
    .msg_ready_o (msg_ready_o),
    .fall_evt    (fall_evt)
);

// File: tb/sync_serial_slave_bench.sv
`timescale 1ns/1ps
module sync_serial_slave_bench;

    localparam int H = 8;   // serial half period in system cycles

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       sdi = 1'b0;
    logic       sel_n = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = '0;
    logic       tx_last = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       sdo;
    logic       sdo_oe;
    logic       msg_ready;

    int n_chk = 0;
    int n_bad = 0;
    int frames = 0;
    int ready_cnt = 0;
    bit finished = 0;

    logic [7:0] exp_rx [$];
    logic [8:0] src [$];     // {last, data}

    always #2 clk = ~clk;

    sync_serial_slave u_sync_serial_slave (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel_n),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .tx_data_i(tx_data), .tx_last_i(tx_last), .tx_valid_i(tx_valid),
        .tx_ready_o(tx_ready), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .msg_ready_o(msg_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected received bytes as the design strobes them (R1, R6)
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_rx.size() == 0) begin
                check("R6 unexpected rx strobe", 32'(rx_data), 32'hFFFF_FFFF);
            end else begin
                check("R1 received byte", 32'(rx_data), 32'(exp_rx.pop_front()));
            end
        end
        if (!rst && tx_ready) ready_cnt++;
    end

    // transmit source driven from its queue
    initial begin
        forever begin
            @(negedge clk);
            tx_valid = (src.size() > 0);
            if (tx_valid) {tx_last, tx_data} = src[0];
            if (tx_ready && tx_valid) begin
                @(posedge clk);
                #1;
                void'(src.pop_front());
            end
        end
    end

    task automatic shift_bits(input int n, input logic [7:0] mosi, output logic [7:0] miso,
                              output logic oe_ok);
        miso = '0;
        oe_ok = 1'b1;
        frames++;
        for (int i = 7; i >= 8 - n; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            sdi  = mosi[i];
            repeat (H) @(negedge clk);
            miso[i] = sdo;
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
    endtask

    // driver: pushes the expected receive byte, then runs the frame and scores the transmit byte
    task automatic xfer(input logic [7:0] mosi, input logic [7:0] exp_miso, input string req);
        logic [7:0] miso;
        logic oe_ok;
        exp_rx.push_back(mosi);
        shift_bits(8, mosi, miso, oe_ok);
        check({req, " transmitted byte"}, 32'(miso), 32'(exp_miso));
        check("R5 output enabled during frame", 32'(oe_ok), 32'd1);
    endtask

    task automatic select(input logic v);
        @(negedge clk);
        sel_n = v;
        repeat (H) @(negedge clk);
    endtask

    initial begin
        logic [7:0] junk;
        logic oe_junk;

        // reset pin states (R4, R8)
        repeat (3) @(negedge clk);
        check("R4 oe in reset with select low", 32'(sdo_oe), 32'd1);
        check("R4 sdo low in reset", 32'(sdo), 32'd0);
        check("R8 msg_ready low in reset", 32'(msg_ready), 32'd0);
        sel_n = 1'b1;
        @(negedge clk);
        check("R4 oe in reset with select high", 32'(sdo_oe), 32'd0);
        check("R1 no rx strobe in reset", 32'(rx_valid), 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R5: enable waits for the first falling edge; R7 padding
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 oe low before first falling edge", 32'(sdo_oe), 32'd0);
        xfer(8'h5A, 8'h00, "R7");
        xfer(8'hC4, 8'h00, "R7");
        @(negedge clk);
        sel_n = 1'b1;
        #1;
        check("R3 oe drops with select", 32'(sdo_oe), 32'd0);
        repeat (H) @(negedge clk);

        // R8: two-byte message
        src.push_back({1'b0, 8'hA5});
        src.push_back({1'b1, 8'h3C});
        repeat (4) @(negedge clk);
        check("R8 msg_ready raised", 32'(msg_ready), 32'd1);
        select(1'b0);
        xfer(8'h81, 8'hA5, "R2");
        check("R8 msg_ready held mid message", 32'(msg_ready), 32'd1);
        xfer(8'h7E, 8'h3C, "R2");
        repeat (2) @(negedge clk);
        check("R8 msg_ready cleared after last byte", 32'(msg_ready), 32'd0);
        xfer(8'h00, 8'h00, "R7");
        select(1'b1);

        // R6: abort after four bits with a byte queued, then a full frame
        src.push_back({1'b1, 8'hE1});
        repeat (4) @(negedge clk);
        select(1'b0);
        shift_bits(4, 8'hF0, junk, oe_junk);
        check("R2 partial frame leading bits", 32'(junk[7:4]), 32'hE);
        select(1'b1);
        check("R3 oe low while deselected", 32'(sdo_oe), 32'd0);
        check("R8 msg_ready kept after abort", 32'(msg_ready), 32'd1);
        src.push_back({1'b1, 8'hC3});
        repeat (4) @(negedge clk);
        select(1'b0);
        xfer(8'h96, 8'hC3, "R6");
        select(1'b1);

        // back-to-back message with varied patterns
        src.push_back({1'b0, 8'h01});
        src.push_back({1'b0, 8'h80});
        src.push_back({1'b1, 8'hF0});
        repeat (4) @(negedge clk);
        select(1'b0);
        xfer(8'hAA, 8'h01, "R2");
        xfer(8'h55, 8'h80, "R2");
        xfer(8'hE7, 8'hF0, "R2");
        repeat (2) @(negedge clk);
        check("R8 msg_ready cleared after third byte", 32'(msg_ready), 32'd0);
        select(1'b1);

        repeat (4) @(negedge clk);
        check("R6 all expected bytes received", 32'(exp_rx.size()), 32'd0);
        check("R9 one ready pulse per frame", 32'(ready_cnt), 32'(frames));
        check("R9 source drained", 32'(src.size()), 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule